// File: doc/BRIEF.md
# Byte-Serial Pipelined Multiply-Accumulate Unit

This block multiplies two 8-bit operands and folds the product into a 16-bit accumulator. Both operands arrive over one shared 8-bit input bus on two back-to-back strobed cycles. The first strobed cycle also carries two mode bits. One picks whether the accumulator is replaced by the product or has the product added to it. The other picks two's-complement or unsigned arithmetic. The work runs through four register stages: capture, operand extension, multiply, and accumulate with overflow flagging.

The 16-bit result goes out over an 8-bit bus. When a new result lands, a ready flag rises and the bus starts on the high byte. It then swaps bytes on every clock edge for as long as the result is shown. An overflow flag reports whether the most recent accumulate left the 16-bit range.

Top module: `serial_mac`

## Requirements
- R1: The first cycle with `strobe` high, seen while idle, samples operand A from `din`. The next cycle samples operand B if `strobe` is still high. If `strobe` is low on that cycle, the operation is dropped and leaves the accumulator and flags untouched. It still lowers `rdy` (see R7).
- R2: `clr_in` and `sgn_in` are sampled only on the operand-A cycle. Their values on the operand-B cycle have no effect.
- R3: With `clr_in`=1 the accumulator becomes the 16-bit product and `ovf` becomes 0.
- R4: With `clr_in`=0 the accumulator becomes (accumulator + product) mod 2^16.
- R5: With `sgn_in`=1 both operands are two's complement, so 0x0A times 0xFB gives 0xFFCE.
- R6: With `sgn_in`=0 both operands are unsigned, so 0xFF times 0xFF gives 0xFE01.
- R7: `rdy` falls on the edge that samples operand A. It rises on the fourth edge after that edge, unless a result commits on the same edge, in which case it stays high. It remains high until the next operand-A edge.
- R8: While `rdy` is high, `dout` shows the accumulator high byte (bits 15:8) first. It swaps between the high byte and the low byte (bits 7:0) on every edge. While `rdy` is low, `dout` is 0.
- R9: In signed mode an accumulate sets `ovf` when the true sum lies outside -32768..32767.
- R10: In unsigned mode an accumulate sets `ovf` when the true sum exceeds 65535.
- R11: `ovf` is recomputed only when a result commits. A clear operation always leaves it 0.
- R12: A synchronous active-low `rst_n` zeroes the accumulator, `ovf`, `rdy` and the pipeline, so `dout` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Operand bus, A then B |
| strobe | input | 1 | Marks the two input cycles |
| clr_in | input | 1 | 1 = replace accumulator, 0 = add to it |
| sgn_in | input | 1 | 1 = two's complement, 0 = unsigned |
| dout | output | 8 | Result byte, high then low, alternating |
| ovf | output | 1 | Overflow of the last committed operation |
| rdy | output | 1 | New result available |

## Verification
The bench targets the cases where a wrong design looks almost right. It flips the mode bits on the operand-B cycle; a design that samples them late would return a signed result for an unsigned request. It abandons an operation after operand A; a design that does not drop it would change the accumulator or raise `rdy` by mistake. It drives accumulations that cross the signed and the unsigned limits, and checks that a later clear lowers `ovf`; a wrong carry or sign rule would show up as a flag that is set when it should be clear, or clear when it should be set. It also checks that `rdy` is still low one edge before it should rise, and that the first byte shown is the high byte. An off-by-one latency or a wrong byte phase would each fail one of these checks.

// File: rtl/serial_mac_pkg.sv
package serial_mac_pkg;
    typedef enum logic {PH_IDLE = 1'b0, PH_HAVE_A = 1'b1} phase_e;

    typedef struct packed {
        logic clr;
        logic sgn;
    } ctl_t;
endpackage

// File: rtl/serial_mac_capture.sv
module serial_mac_capture
    import serial_mac_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         strobe,
    input  logic         clr_in,
    input  logic         sgn_in,
    output logic         start,
    output logic         v_out,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output ctl_t         ctl_out
);
    typedef struct packed {
        phase_e       phase;
        logic [W-1:0] a_hold;
        ctl_t         ctl_hold;
        logic         v;
        logic [W-1:0] a;
        logic [W-1:0] b;
        ctl_t         ctl;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = 1'b0;
        start  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (strobe) begin
                    start           = 1'b1;
                    st_d.a_hold     = din;
                    st_d.ctl_hold   = '{clr: clr_in, sgn: sgn_in};
                    st_d.phase      = PH_HAVE_A;
                end
            end
            default: begin
                if (strobe) begin
                    st_d.v   = 1'b1;
                    st_d.a   = st_q.a_hold;
                    st_d.b   = din;
                    st_d.ctl = st_q.ctl_hold;
                end
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_out   = st_q.v;
    assign a_out   = st_q.a;
    assign b_out   = st_q.b;
    assign ctl_out = st_q.ctl;

    // R1
    two_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v |-> ($past(strobe, 1) && $past(strobe, 2)));
endmodule

// File: rtl/serial_mac_extend.sv
module serial_mac_extend
    import serial_mac_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_in,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  ctl_t          ctl_in,
    output logic          v_out,
    output logic [PW-1:0] ax_out,
    output logic [PW-1:0] bx_out,
    output ctl_t          ctl_out
);
    typedef struct packed {
        logic          v;
        logic [PW-1:0] ax;
        logic [PW-1:0] bx;
        ctl_t          ctl;
    } ext_t;

    ext_t st_d, st_q;
    logic a_fill, b_fill;

    always_comb begin
        st_d   = st_q;
        a_fill = ctl_in.sgn & a_in[W-1];
        b_fill = ctl_in.sgn & b_in[W-1];
        st_d.v = v_in;
        if (v_in) begin
            st_d.ax  = {{W{a_fill}}, a_in};
            st_d.bx  = {{W{b_fill}}, b_in};
            st_d.ctl = ctl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_out   = st_q.v;
    assign ax_out  = st_q.ax;
    assign bx_out  = st_q.bx;
    assign ctl_out = st_q.ctl;

    // R6
    unsigned_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && !ctl_in.sgn) |=> (st_q.ax[PW-1:W] == '0 && st_q.bx[PW-1:W] == '0));
endmodule

// File: rtl/serial_mac_mult.sv
module serial_mac_mult
    import serial_mac_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_in,
    input  logic [PW-1:0] ax_in,
    input  logic [PW-1:0] bx_in,
    input  ctl_t          ctl_in,
    output logic          v_out,
    output logic [PW-1:0] prod_out,
    output ctl_t          ctl_out
);
    typedef struct packed {
        logic          v;
        logic [PW-1:0] prod;
        ctl_t          ctl;
    } mul_t;

    mul_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = v_in;
        if (v_in) begin
            st_d.prod = ax_in * bx_in;
            st_d.ctl  = ctl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_out    = st_q.v;
    assign prod_out = st_q.prod;
    assign ctl_out  = st_q.ctl;

    // R7
    mult_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> st_q.v);
endmodule

// File: rtl/serial_mac_accum.sv
module serial_mac_accum
    import serial_mac_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_in,
    input  logic [PW-1:0] prod_in,
    input  ctl_t          ctl_in,
    input  logic          start,
    output logic [W-1:0]  dout,
    output logic          ovf,
    output logic          rdy
);
    typedef struct packed {
        logic [PW-1:0] acc;
        logic          ovf;
        logic          rdy;
        logic          hi;
    } acc_t;

    acc_t st_d, st_q;
    logic [PW:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {1'b0, prod_in};
        if (v_in) begin
            if (ctl_in.clr) begin
                st_d.acc = prod_in;
                st_d.ovf = 1'b0;
            end else begin
                st_d.acc = sum[PW-1:0];
                if (ctl_in.sgn)
                    st_d.ovf = (st_q.acc[PW-1] == prod_in[PW-1]) &&
                               (sum[PW-1] != st_q.acc[PW-1]);
                else
                    st_d.ovf = sum[PW];
            end
            st_d.rdy = 1'b1;
            st_d.hi  = 1'b1;
        end else begin
            if (start)     st_d.rdy = 1'b0;
            if (st_q.rdy)  st_d.hi  = ~st_q.hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = !st_q.rdy ? '0 : (st_q.hi ? st_q.acc[PW-1:W] : st_q.acc[W-1:0]);
    assign ovf  = st_q.ovf;
    assign rdy  = st_q.rdy;

    // R11
    clear_drops_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && ctl_in.clr) |=> !st_q.ovf);

    // R11
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> $stable(st_q.ovf));

    // R8
    byte_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rdy && !v_in && !start) |=> (st_q.hi != $past(st_q.hi)));

    // R7
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rdy) |-> ($past(v_in) && st_q.hi));
endmodule

// File: rtl/serial_mac.sv
module serial_mac
    import serial_mac_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         strobe,
    input  logic         clr_in,
    input  logic         sgn_in,
    output logic [W-1:0] dout,
    output logic         ovf,
    output logic         rdy
);
    logic          start;
    logic          v1, v2, v3;
    logic [W-1:0]  a1, b1;
    logic [PW-1:0] ax2, bx2, prod3;
    ctl_t          ctl1, ctl2, ctl3;

    serial_mac_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .din(din), .strobe(strobe),
        .clr_in(clr_in), .sgn_in(sgn_in), .start(start),
        .v_out(v1), .a_out(a1), .b_out(b1), .ctl_out(ctl1)
    );

    serial_mac_extend #(.W(W)) u_ext (
        .clk(clk), .rst_n(rst_n), .v_in(v1), .a_in(a1), .b_in(b1),
        .ctl_in(ctl1), .v_out(v2), .ax_out(ax2), .bx_out(bx2), .ctl_out(ctl2)
    );

    serial_mac_mult #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .v_in(v2), .ax_in(ax2), .bx_in(bx2),
        .ctl_in(ctl2), .v_out(v3), .prod_out(prod3), .ctl_out(ctl3)
    );

    serial_mac_accum #(.W(W)) u_acc (
        .clk(clk), .rst_n(rst_n), .v_in(v3), .prod_in(prod3), .ctl_in(ctl3),
        .start(start), .dout(dout), .ovf(ovf), .rdy(rdy)
    );
endmodule

// File: tb/test_serial_mac.sv
module test_serial_mac;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic       strobe = 1'b0, clr_in = 1'b0, sgn_in = 1'b0;
    logic [7:0] dout;
    logic       ovf, rdy;

    int nvec = 0, nbad = 0;
    bit done = 1'b0;
    logic [15:0] m_acc = '0;
    logic        m_ovf = 1'b0;

    always #10 clk = ~clk;

    serial_mac i_serial_mac (
        .clk(clk), .rst_n(rst_n), .din(din), .strobe(strobe),
        .clr_in(clr_in), .sgn_in(sgn_in), .dout(dout), .ovf(ovf), .rdy(rdy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_prod(input logic [7:0] a, input logic [7:0] b, input logic s);
        int p;
        if (s) p = int'($signed(a)) * int'($signed(b));
        else   p = int'(a) * int'(b);
        return p[15:0];
    endfunction

    task automatic model(input logic [7:0] a, input logic [7:0] b, input logic c, input logic s);
        logic [15:0] p;
        int t;
        p = f_prod(a, b, s);
        if (c) begin
            m_acc = p;
            m_ovf = 1'b0;
        end else begin
            if (s) begin
                t = int'($signed(m_acc)) + int'($signed(p));
                m_ovf = (t > 32767) || (t < -32768);
            end else begin
                t = int'(m_acc) + int'(p);
                m_ovf = (t > 65535);
            end
            m_acc = m_acc + p;
        end
    endtask

    task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic c,
                          input logic s, input logic c2, input logic s2);
        model(a, b, c, s);
        @(negedge clk); strobe = 1'b1; din = a; clr_in = c;  sgn_in = s;
        @(negedge clk); din = b; clr_in = c2; sgn_in = s2;
        @(negedge clk); strobe = 1'b0; din = 8'($urandom); clr_in = 1'($urandom); sgn_in = 1'($urandom);
        chk("R7 rdy low after A edge", 16'(rdy), 16'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R7 rdy low one edge early", 16'(rdy), 16'd0);
        @(negedge clk);
        chk("R7 rdy high", 16'(rdy), 16'd1);
        chk("R8 high byte first (R3 R4 R5 R6)", 16'(dout), 16'(m_acc[15:8]));
        chk("R9 R10 R11 overflow", 16'(ovf), 16'(m_ovf));
        @(negedge clk);
        chk("R8 low byte", 16'(dout), 16'(m_acc[7:0]));
        @(negedge clk);
        chk("R8 high byte again", 16'(dout), 16'(m_acc[15:8]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 rdy after reset", 16'(rdy), 16'd0);
        chk("R12 dout after reset", 16'(dout), 16'd0);
        chk("R12 ovf after reset", 16'(ovf), 16'd0);

        // R5 signed example
        run_op(8'h0A, 8'hFB, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R5 signed 10*-5", m_acc, 16'hFFCE);
        // R3 then R4
        run_op(8'd10, 8'd10, 1'b1, 1'b0, 1'b1, 1'b1);
        run_op(8'd5, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 100+25", m_acc, 16'h007D);
        // R2 mode bits on second cycle ignored, R6 unsigned
        run_op(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R6 unsigned FF*FF", m_acc, 16'hFE01);
        // R10 unsigned overflow
        run_op(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 unsigned carry model", 16'(m_ovf), 16'd1);
        // R9 signed overflow
        run_op(8'h80, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0);
        run_op(8'h80, 8'h80, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R9 signed overflow model", 16'(m_ovf), 16'd1);
        // R11 clear drops overflow
        run_op(8'h02, 8'h03, 1'b1, 1'b0, 1'b0, 1'b1);

        // R1 abandoned operation
        @(negedge clk); strobe = 1'b1; din = 8'h77; clr_in = 1'b1; sgn_in = 1'b1;
        @(negedge clk); strobe = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R1 no result from dropped op", 16'(rdy), 16'd0);
        end
        run_op(8'h01, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 acc untouched by dropped op", m_acc, 16'h0007);

        // R12 reset mid-run clears accumulator
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R12 rdy cleared by reset", 16'(rdy), 16'd0);
        m_acc = '0; m_ovf = 1'b0;
        run_op(8'h01, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R12 acc zero after reset", m_acc, 16'h0001);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic c;
            c = (($urandom % 5) == 0);
            run_op(8'($urandom), 8'($urandom), c, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule